// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Status Flags

This block is the arithmetic and logic core of a small 16-bit processor datapath. Two operands and a 3-bit operation code enter the block, and a combinational result leaves it in the same cycle. Each operation also produces carry, zero, negative and overflow flags. These are captured on the next clock edge into a status register that also holds a global interrupt-enable bit. Operations that only move data leave every flag alone. Compare runs a subtraction whose only lasting effect is on the flags.

For subtraction and compare, the carry flag acts as an inverted borrow: it is 1 when the minuend is not below the subtrahend (unsigned) and 0 when a borrow was needed. The status register can also be loaded directly through a write port. This port is the only path that changes the interrupt-enable bit.

Top module: `alu_sr_core`

## Requirements
- R1: Opcode 0 (add) gives result A+B mod 2^16. On the next edge, C takes the carry out of bit 15, and V is set when A and B have the same sign bit and the result's sign bit differs from it.
- R2: Opcode 1 (add with carry) gives result A+B+C, where C is the stored carry flag. C and V follow the rule of R1 applied to this sum.
- R3: Opcode 2 (subtract) gives result A-B mod 2^16. On the next edge, C is 1 exactly when A >= B unsigned (no borrow). V is set when A and B differ in sign and the result's sign differs from A.
- R4: Opcode 3 (compare) updates the flags exactly as opcode 2 does. It holds res_wr low, while result still shows A-B.
- R5: Opcode 4 (AND) and opcode 5 (XOR) give the bitwise result. C becomes 1 when the result is nonzero, and V becomes 0.
- R6: Opcode 7 (rotate right through carry) gives the result {C, A[15:1]}. On the next edge, C takes A[0] and V becomes 0.
- R7: After any flag-updating operation (every opcode but 6), Z is 1 exactly when the 16-bit result was zero, and N equals result bit 15.
- R8: Opcode 6 (move) gives result B and leaves C, Z, N, V and GIE unchanged.
- R9: When sr_wr is high, the next edge loads the flags from sr_wr_data: bit 0 to C, bit 1 to Z, bit 2 to N, bit 3 to V, bit 4 to GIE. This load takes priority over an operation in the same cycle.
- R10: GIE changes only through the status write port, never through an operation.
- R11: Synchronous reset clears all five status bits. A cycle with neither op_valid nor sr_wr leaves them unchanged.
- R12: Adding 0x9A4F and 0xC3D0 gives 0x5E1F with C=1 and V=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation selector (see requirements) |
| opnd_a | input | 16 | First operand (destination source) |
| opnd_b | input | 16 | Second operand |
| sr_wr | input | 1 | Direct status register load |
| sr_wr_data | input | 5 | Status load value {GIE,V,N,Z,C} |
| result | output | 16 | Combinational operation result |
| res_wr | output | 1 | Result should be written back |
| flag_c | output | 1 | Carry / inverted borrow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_v | output | 1 | Signed overflow |
| flag_gie | output | 1 | Global interrupt enable |

## Verification
The result is combinational, so a wrong adder or mux path shows up in the same cycle as the operands. A wrong flag update shows up one edge later at the flag pins. A carry error that only appears through add-with-carry or rotate is visible one operation after that, because the stored C feeds those operations. The operand sweep covers sign and carry boundaries, and it is repeated with different preloaded flags. This exposes both flags that should have held and flags that should have changed.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_CMP  = 3'd3,
    OP_AND  = 3'd4,
    OP_XOR  = 3'd5,
    OP_MOV  = 3'd6,
    OP_RRC  = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic gie;
    logic v;
    logic n;
    logic z;
    logic c;
  } status_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             invert_b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    b_eff = invert_b ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
    sum   = wide[WIDTH-1:0];
    cout  = wide[WIDTH];
    ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       sel,
  input  logic             cin,
  output logic [WIDTH-1:0] y,
  output logic             cout
);
  always_comb begin
    cout = 1'b0;
    unique case (sel)
      2'd0: y = a & b;
      2'd1: y = a ^ b;
      2'd2: y = b;
      default: begin
        y    = {cin, a[WIDTH-1:1]};
        cout = a[0];
      end
    endcase
    if (sel != 2'd3) cout = |y;
  end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sr_wr,
  input  status_t sr_data,
  input  logic    upd_en,
  input  logic    c_in,
  input  logic    z_in,
  input  logic    n_in,
  input  logic    v_in,
  output status_t sr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (sr_wr) begin
      sr_q <= sr_data;
    end else if (upd_en) begin
      sr_q.c <= c_in;
      sr_q.z <= z_in;
      sr_q.n <= n_in;
      sr_q.v <= v_in;
    end
  end

  AST_SR_LOAD: assert property (@(posedge clk) disable iff (rst)
    sr_wr |=> sr_q == $past(sr_data)); // R9
  AST_GIE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sr_wr |=> $stable(sr_q.gie)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sr_wr && !upd_en) |=> $stable(sr_q)); // R11
endmodule

// File: rtl/alu_sr_core.sv
module alu_sr_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             sr_wr,
  input  logic [4:0]       sr_wr_data,
  output logic [WIDTH-1:0] result,
  output logic             res_wr,
  output logic             flag_c,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_v,
  output logic             flag_gie
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  status_t          sr_q;
  logic             is_arith;
  logic             sub_mode;
  logic             add_cin;
  logic [WIDTH-1:0] arith_y;
  logic             arith_c;
  logic             arith_v;
  logic [WIDTH-1:0] logic_y;
  logic             logic_c;
  logic             new_c;
  logic             new_v;
  logic             upd_en;

  assign op       = alu_op_e'(op_code);
  assign is_arith = (op_code[2] == 1'b0);
  assign sub_mode = (op == OP_SUB) || (op == OP_CMP);
  assign add_cin  = sub_mode ? 1'b1 : ((op == OP_ADDC) ? sr_q.c : 1'b0);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(opnd_a), .b(opnd_b), .invert_b(sub_mode), .cin(add_cin),
    .sum(arith_y), .cout(arith_c), .ovf(arith_v)
  );

  alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a(opnd_a), .b(opnd_b), .sel(op_code[1:0]), .cin(sr_q.c),
    .y(logic_y), .cout(logic_c)
  );

  always_comb begin
    result = is_arith ? arith_y : logic_y;
    new_c  = is_arith ? arith_c : logic_c;
    new_v  = is_arith ? arith_v : 1'b0;
    res_wr = op_valid && (op != OP_CMP);
    upd_en = op_valid && (op != OP_MOV);
  end

  alu_status_reg u_sr (
    .clk(clk), .rst(rst), .sr_wr(sr_wr), .sr_data(status_t'(sr_wr_data)),
    .upd_en(upd_en), .c_in(new_c), .z_in(result == '0), .n_in(result[MSB]),
    .v_in(new_v), .sr_q(sr_q)
  );

  assign flag_c   = sr_q.c;
  assign flag_z   = sr_q.z;
  assign flag_n   = sr_q.n;
  assign flag_v   = sr_q.v;
  assign flag_gie = sr_q.gie;

  AST_MOV_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sr_wr && op_code == 3'd6) |=>
      $stable({flag_gie, flag_v, flag_n, flag_z, flag_c})); // R8
  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sr_wr && op_code != 3'd6) |=>
      (flag_z == ($past(result) == '0)) && (flag_n == $past(result[MSB]))); // R7
  AST_LOGIC_V_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sr_wr && op_code[2] && op_code != 3'd6) |=> !flag_v); // R5
  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !sr_wr && (op_code == 3'd2 || op_code == 3'd3)) |=>
      flag_c == ($past(opnd_a) >= $past(opnd_b))); // R3
endmodule

// File: tb/alu_sr_core_bench.sv
module alu_sr_core_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [15:0] opnd_a, opnd_b;
  logic        sr_wr;
  logic [4:0]  sr_wr_data;
  logic [15:0] result;
  logic        res_wr, flag_c, flag_z, flag_n, flag_v, flag_gie;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_sr_core #(.WIDTH(16)) u_alu_sr_core (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sr_wr(sr_wr), .sr_wr_data(sr_wr_data),
    .result(result), .res_wr(res_wr), .flag_c(flag_c), .flag_z(flag_z),
    .flag_n(flag_n), .flag_v(flag_v), .flag_gie(flag_gie)
  );

  function automatic logic [15:0] corner(int i);
    case (i)
      0: corner = 16'h0000;  1: corner = 16'h0001;  2: corner = 16'h7FFF;
      3: corner = 16'h8000;  4: corner = 16'hFFFF;  5: corner = 16'h9A4F;
      6: corner = 16'hC3D0;  7: corner = 16'h8001;  8: corner = 16'h7FFE;
      9: corner = 16'h5555;  10: corner = 16'hAAAA; default: corner = 16'h1234;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_sr(logic [4:0] d);
    @(negedge clk);
    sr_wr = 1'b1; sr_wr_data = d; op_valid = 1'b0;
    @(negedge clk);
    sr_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; op_valid = 0; op_code = 0; opnd_a = 0; opnd_b = 0;
    sr_wr = 0; sr_wr_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset", {flag_gie, flag_v, flag_n, flag_z, flag_c}, 5'b0);

    // R12 worked example
    op_valid = 1; op_code = 3'd0; opnd_a = 16'h9A4F; opnd_b = 16'hC3D0;
    #1 check("R12 result", result, 16'h5E1F);
    @(negedge clk);
    op_valid = 0;
    check("R12 C/V", {flag_c, flag_v}, 2'b11);

    // R11 idle: inputs toggle with op_valid low
    op_code = 3'd4; opnd_a = 16'h0; opnd_b = 16'h0;
    @(negedge clk);
    check("R11 idle hold", {flag_gie, flag_v, flag_n, flag_z, flag_c}, 5'b01001);

    // R9 priority of status write over operation
    sr_wr = 1; sr_wr_data = 5'b10110; op_valid = 1; op_code = 3'd0;
    opnd_a = 16'h0001; opnd_b = 16'h0001;
    @(negedge clk);
    sr_wr = 0; op_valid = 0;
    check("R9 priority", {flag_gie, flag_v, flag_n, flag_z, flag_c}, 5'b10110);

    // Sweep: op x a x b x preloaded flags
    for (int pre = 0; pre < 2; pre++) begin
      for (int op = 0; op < 8; op++) begin
        for (int ia = 0; ia < 12; ia++) begin
          for (int ib = 0; ib < 12; ib++) begin
            logic [4:0]  p;
            logic [15:0] a, b, er;
            logic [16:0] wide;
            logic ec, ez, en, ev;
            p = pre[0] ? 5'b10101 : 5'b01010;
            a = corner(ia); b = corner(ib);
            load_sr(p);
            check("R9 load", {flag_gie, flag_v, flag_n, flag_z, flag_c}, p);
            ev = 1'b0; ec = 1'b0;
            case (op)
              0, 1: begin
                wide = {1'b0, a} + {1'b0, b} + ((op == 1) ? {16'b0, p[0]} : 17'd0);
                er = wide[15:0]; ec = wide[16];
                ev = (a[15] == b[15]) && (er[15] != a[15]);
              end
              2, 3: begin
                er = a - b; ec = (a >= b);
                ev = (a[15] != b[15]) && (er[15] != a[15]);
              end
              4: begin er = a & b; ec = (er != 0); end
              5: begin er = a ^ b; ec = (er != 0); end
              6: er = b;
              default: begin er = {p[0], a[15:1]}; ec = a[0]; end
            endcase
            ez = (er == 0); en = er[15];
            op_valid = 1; op_code = op[2:0]; opnd_a = a; opnd_b = b;
            #1;
            case (op)
              0: check("R1 add result", result, er);
              1: check("R2 addc result", result, er);
              2: check("R3 sub result", result, er);
              3: check("R4 cmp result", result, er);
              4, 5: check("R5 logic result", result, er);
              6: check("R8 mov result", result, er);
              default: check("R6 rrc result", result, er);
            endcase
            check("R4 res_wr", res_wr, (op != 3));
            @(negedge clk);
            op_valid = 0;
            if (op == 6)
              check("R8 flags held", {flag_gie, flag_v, flag_n, flag_z, flag_c}, p);
            else begin
              check("R7 Z/N", {flag_z, flag_n}, {ez, en});
              case (op)
                0: check("R1 C/V", {flag_c, flag_v}, {ec, ev});
                1: check("R2 C/V", {flag_c, flag_v}, {ec, ev});
                2: check("R3 C/V", {flag_c, flag_v}, {ec, ev});
                3: check("R4 C/V", {flag_c, flag_v}, {ec, ev});
                4, 5: check("R5 C/V", {flag_c, flag_v}, {ec, ev});
                default: check("R6 C/V", {flag_c, flag_v}, {ec, ev});
              endcase
              check("R10 gie", flag_gie, p[4]);
            end
          end
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule